// File: doc/BRIEF.md
# Spare-Column Substitution and Parity Controller

This block sits between a memory array and the port that reads and writes it. Every stored word holds 16 data bits, one parity bit and one extra column kept in reserve. When a single data-bit column of a memory module is known to be stuck, a small configuration register is loaded with that column's number and an enable flag. From then on every write also copies that data bit into the reserve column, and every read takes the bit back from the reserve column, so the stuck column no longer affects the data.

Parity is generated on writes and checked on reads over the 16 logical data bits after substitution. A remapped fault therefore raises no error. A test input makes the generator write even parity instead of odd, so the checker can be exercised. A parity mismatch on a read gives a one-cycle error pulse, and the failing address is kept in a hold register until it is cleared. The configuration may not change while accesses are in flight. A new value written during traffic is held pending and takes effect only when the port is idle. Each memory module has its own instance, so each module is configured on its own.

Top module: `spare_col_ctrl`

## Requirements
- R1: During and right after reset, cfg_q, mem_en, mem_we, rd_valid, par_err and err_held are all 0. The reserve column is disabled.
- R2: A request sampled at a clock edge appears on mem_en, mem_we, mem_addr for exactly one cycle after that edge. For a write, mem_wword[15:0] equals the written data.
- R3: The configuration word has cfg_wdata[4] as the enable and cfg_wdata[3:0] as the column number. While enabled, mem_wword[17] equals data bit [column]. While disabled, mem_wword[17] is 0.
- R4: mem_wword[16] is the parity bit. With par_test low, bits [16:0] hold an odd number of ones. With par_test high, they hold an even number.
- R5: The memory returns the stored word on mem_rword RD_LAT cycles after the cycle in which mem_en is high for a read. rd_valid is then high for one cycle, RD_LAT+1 edges after the edge that sampled the request. While the reserve column is disabled, rd_data equals mem_rword[15:0].
- R6: While the reserve column is enabled, rd_data bit [column] is taken from mem_rword[17]. The stored value of that data column is ignored. All other bits come from mem_rword[15:0].
- R7: par_err pulses together with rd_valid exactly when the substituted 16 data bits plus mem_rword[16] hold an even number of ones. It is never high without rd_valid.
- R8: On a parity error with no address held, err_addr captures the failing address and err_held goes high in the same cycle as par_err. Later errors leave err_addr unchanged. err_clr drops err_held. An error arriving in the same cycle as err_clr is captured.
- R9: A configuration write is applied at the end of the first cycle with no request and no access in flight. cfg_q shows the active value. While traffic is in flight, the old value stays active.
- R10: Several configuration writes made while busy collapse to the last one, which is then applied once the port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 5 | Bit 4 is the enable, bits 3:0 the column number |
| cfg_q | output | 5 | Active configuration |
| par_test | input | 1 | Generate even parity on this write |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 16 | Write data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 10 | Memory address |
| mem_wword | output | 18 | Stored word: reserve, parity, data |
| mem_rword | input | 18 | Word returned by the memory |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data after substitution |
| par_err | output | 1 | One-cycle parity error pulse |
| err_clr | input | 1 | Clears the held error address |
| err_held | output | 1 | An error address is held |
| err_addr | output | 10 | Address of the first held error |

## Verification
The bench builds the block with the full 16-bit data width, so every column number from 0 to 15 can be selected. It uses a 5-bit address, so random reads often hit words written earlier under a different configuration, parity mode or injected stuck column. RD_LAT is set to 3 rather than the default 2. This leaves several reads in flight when configuration writes arrive, so both the pending path and the last-write-wins path occur with traffic present.

// File: rtl/spare_col_pkg.sv
// Shared definitions for the spare-column controller.
// Assumes parity is always computed over logical (post-substitution) data.
package spare_col_pkg;

    typedef enum logic {
        PAR_ODD  = 1'b0,
        PAR_EVEN = 1'b1
    } par_mode_e;

    // Return the parity bit that, together with data whose XOR is red_xor,
    // gives the requested parity sense.
    function automatic logic parity_bit(input logic red_xor, input par_mode_e mode);
        return (mode == PAR_ODD) ? ~red_xor : red_xor;
    endfunction

endpackage

// File: rtl/spare_cfg_reg.sv
// Configuration register for the spare column: {enable, column}.
// A new value is applied only in a cycle where busy_i is low; while busy,
// writes go to a pending slot where the last write wins.
module spare_cfg_reg #(
    parameter int DATA_W = 16,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [SEL_W:0]   cfg_wdata_i,
    input  logic             busy_i,
    output logic [SEL_W:0]   cfg_q_o,
    output logic             use_spare_o,
    output logic [SEL_W-1:0] sel_o
);

    logic [SEL_W:0] act_q;
    logic [SEL_W:0] pend_q;
    logic           pend_v_q;

    // Hold pending writes while busy, apply on the first idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (!busy_i) begin
            if (cfg_we_i) begin
                act_q <= cfg_wdata_i;
            end else if (pend_v_q) begin
                act_q <= pend_q;
            end
            pend_v_q <= 1'b0;
        end else if (cfg_we_i) begin
            pend_q   <= cfg_wdata_i;
            pend_v_q <= 1'b1;
        end
    end

    assign cfg_q_o = act_q;
    assign sel_o   = act_q[SEL_W-1:0];

    // Column numbers past DATA_W exist only for non power-of-two widths.
    generate
        if ((1 << SEL_W) > DATA_W) begin : g_range_guard
            localparam logic [SEL_W:0] LIMIT = DATA_W[SEL_W:0];
            assign use_spare_o = act_q[SEL_W] && ({1'b0, act_q[SEL_W-1:0]} < LIMIT);
        end else begin : g_full_range
            assign use_spare_o = act_q[SEL_W];
        end
    endgenerate

    // R9: the active value moves only after an idle cycle
    p_cfg_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q_o) |-> $past(!busy_i));

    // R10: a pending value is applied on the next idle cycle without a new write
    p_pend_apply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v_q && !busy_i && !cfg_we_i |=> cfg_q_o == $past(pend_q));

endmodule

// File: rtl/spare_wr_path.sv
// Issue path: registers each request onto the memory side and builds the
// stored word {spare copy, parity, data} for writes.
// Assumes at most one request per cycle and a memory that accepts every cycle.
module spare_wr_path
    import spare_col_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              par_test_i,
    input  logic              use_spare_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W+1:0] mem_wword_o
);

    par_mode_e         mode;
    logic              spare_bit;
    logic              par;
    logic [DATA_W+1:0] word;

    // Build the stored word from the logical write data.
    always_comb begin
        mode      = par_test_i ? PAR_EVEN : PAR_ODD;
        spare_bit = use_spare_i ? req_wdata_i[sel_i] : 1'b0;
        par       = parity_bit(^req_wdata_i, mode);
        word      = {spare_bit, par, req_wdata_i};
    end

    // Register the request onto the memory side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_en_o    <= 1'b0;
            mem_we_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_wword_o <= '0;
        end else begin
            mem_en_o    <= req_valid_i;
            mem_we_o    <= req_valid_i && req_write_i;
            mem_addr_o  <= req_addr_i;
            mem_wword_o <= word;
        end
    end

    // R4: stored parity sense follows the test input of the issuing cycle
    p_parity_sense_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o && mem_we_o |-> (^mem_wword_o[DATA_W:0]) == !$past(par_test_i));

    // R2: no write strobe without an access strobe
    p_we_in_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_en_o);

endmodule

// File: rtl/spare_rd_path.sv
// Return path: tracks reads in flight through a RD_LAT-deep tag pipeline,
// rebuilds logical data from the returned word and checks parity.
// Assumes the memory presents the word exactly RD_LAT cycles after mem_en.
module spare_rd_path #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    parameter int SEL_W  = $clog2(DATA_W),
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              use_spare_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W+1:0] mem_rword_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              par_err_o,
    output logic              err_strobe_o,
    output logic [ADDR_W-1:0] err_at_o,
    output logic              busy_o
);

    localparam int DEPTH = RD_LAT + 1;
    localparam int LAST  = DEPTH - 1;
    localparam int SPARE = DATA_W + 1;
    localparam int PARB  = DATA_W;

    logic [DEPTH-1:0]             v_q;
    logic [DEPTH-1:0][ADDR_W-1:0] a_q;
    logic [DATA_W-1:0]            fixed;
    logic                         bad;

    // Shift read tags along with the memory latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            a_q <= '0;
        end else begin
            v_q[0] <= req_valid_i && !req_write_i;
            a_q[0] <= req_addr_i;
            for (int k = 1; k < DEPTH; k++) begin
                v_q[k] <= v_q[k-1];
                a_q[k] <= a_q[k-1];
            end
        end
    end

    // Put the spare bit back in its column and check odd parity.
    always_comb begin
        fixed = mem_rword_i[DATA_W-1:0];
        if (use_spare_i) begin
            fixed[sel_i] = mem_rword_i[SPARE];
        end
        bad = ~^{fixed, mem_rword_i[PARB]};
    end

    assign err_strobe_o = v_q[LAST] && bad;
    assign err_at_o     = a_q[LAST];
    assign busy_o       = |v_q;

    // Register the read result and its error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            par_err_o  <= 1'b0;
        end else begin
            rd_valid_o <= v_q[LAST];
            par_err_o  <= err_strobe_o;
            if (v_q[LAST]) begin
                rd_data_o <= fixed;
            end
        end
    end

    // R7: an error pulse only comes with returned data
    p_err_with_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |-> rd_valid_o);

    // R5: with the spare disabled, returned data passes unchanged
    p_plain_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        v_q[LAST] && !use_spare_i |=> rd_data_o == $past(mem_rword_i[DATA_W-1:0]));

endmodule

// File: rtl/spare_err_hold.sv
// Holds the address of the first parity error until cleared.
// An error in the same cycle as a clear is captured as the new first error.
module spare_err_hold #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_i,
    output logic              held_o,
    output logic [ADDR_W-1:0] addr_o
);

    // Capture the first error, release on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_o <= 1'b0;
            addr_o <= '0;
        end else if (strobe_i && (!held_o || clr_i)) begin
            held_o <= 1'b1;
            addr_o <= addr_i;
        end else if (clr_i) begin
            held_o <= 1'b0;
        end
    end

    // R8: a held address survives later errors until cleared
    p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        held_o && !clr_i |=> held_o && $stable(addr_o));

    // R8: clear without a new error releases the hold
    p_hold_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !strobe_i |=> !held_o);

endmodule

// File: rtl/spare_col_ctrl.sv
// Top: spare-column substitution controller for one memory module.
// Wires the configuration register, issue path, return path and error hold.
// Assumes one request per cycle and a fixed memory read latency RD_LAT >= 1.
module spare_col_ctrl #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    parameter int RD_LAT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(DATA_W):0]  cfg_wdata,
    output logic [$clog2(DATA_W):0]  cfg_q,
    input  logic                     par_test,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W+1:0]        mem_wword,
    input  logic [DATA_W+1:0]        mem_rword,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     par_err,
    input  logic                     err_clr,
    output logic                     err_held,
    output logic [ADDR_W-1:0]        err_addr
);

    localparam int SEL_W = $clog2(DATA_W);

    logic             use_spare;
    logic [SEL_W-1:0] sel;
    logic             rd_busy;
    logic             busy;
    logic             err_strobe;
    logic [ADDR_W-1:0] err_at;
    logic [DATA_W-1:0] wdata_field;

    // Port is busy with a new request, an issue in progress or reads in flight.
    assign busy = req_valid || mem_en || rd_busy;

    spare_cfg_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wdata),
        .busy_i      (busy),
        .cfg_q_o     (cfg_q),
        .use_spare_o (use_spare),
        .sel_o       (sel)
    );

    spare_wr_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .par_test_i  (par_test),
        .use_spare_i (use_spare),
        .sel_i       (sel),
        .mem_en_o    (mem_en),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wword_o (mem_wword)
    );

    spare_rd_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .RD_LAT(RD_LAT)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_write_i  (req_write),
        .req_addr_i   (req_addr),
        .use_spare_i  (use_spare),
        .sel_i        (sel),
        .mem_rword_i  (mem_rword),
        .rd_valid_o   (rd_valid),
        .rd_data_o    (rd_data),
        .par_err_o    (par_err),
        .err_strobe_o (err_strobe),
        .err_at_o     (err_at),
        .busy_o       (rd_busy)
    );

    spare_err_hold #(.ADDR_W(ADDR_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (err_strobe),
        .addr_i   (err_at),
        .clr_i    (err_clr),
        .held_o   (err_held),
        .addr_o   (err_addr)
    );

    assign wdata_field = mem_wword[DATA_W-1:0];

    // R3: an enabled spare column carries a copy of the selected data bit
    p_spare_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && mem_we && use_spare |-> mem_wword[DATA_W+1] == wdata_field[sel]);

    // R3: a disabled spare column is written as zero
    p_spare_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && mem_we && !use_spare |-> !mem_wword[DATA_W+1]);

endmodule

// File: tb/sim_spare_col_ctrl.sv
module sim_spare_col_ctrl;
    localparam int DW  = 16;
    localparam int AW  = 5;
    localparam int LAT = 3;
    localparam int WW  = DW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cfg_we = 0;
    logic [4:0]    cfg_wdata = '0;
    logic [4:0]    cfg_q;
    logic          par_test = 0;
    logic          req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wword, mem_rword;
    logic          rd_valid, par_err, err_held;
    logic [DW-1:0] rd_data;
    logic          err_clr = 0;
    logic [AW-1:0] err_addr;

    spare_col_ctrl #(.DATA_W(DW), .ADDR_W(AW), .RD_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .par_test(par_test), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wword(mem_wword), .mem_rword(mem_rword),
        .rd_valid(rd_valid), .rd_data(rd_data), .par_err(par_err), .err_clr(err_clr),
        .err_held(err_held), .err_addr(err_addr)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0, mon_on = 0;
    int stuck_col = -1;
    logic stuck_val = 1'b0;

    // Encoding per R3/R4: {spare, parity, data}
    function automatic logic [WW-1:0] enc(input logic [DW-1:0] d, input logic en,
                                          input logic [3:0] sel, input logic test);
        logic p;
        p = test ? ^d : ~^d;
        return {en ? d[sel] : 1'b0, p, d};
    endfunction

    // Decoding per R5/R6/R7: {error, data}
    function automatic logic [DW:0] dec(input logic [WW-1:0] w, input logic en,
                                        input logic [3:0] sel);
        logic [DW-1:0] x;
        x = w[DW-1:0];
        if (en) x[sel] = w[DW+1];
        return {~^{x, w[DW]}, x};
    endfunction

    function automatic logic [WW-1:0] fault(input logic [WW-1:0] w);
        logic [WW-1:0] r;
        r = w;
        if (stuck_col >= 0) r[stuck_col] = stuck_val;
        return r;
    endfunction

    // Memory model with a stuck column applied on read.
    logic [WW-1:0] store [0:(1<<AW)-1];
    logic [WW-1:0] rpipe [0:LAT-1];
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) store[i] <= 18'h10000;
            for (int i = 0; i < LAT; i++) rpipe[i] <= '0;
        end else begin
            if (mem_en && mem_we) store[mem_addr] <= mem_wword;
            if (mem_en && !mem_we) rpipe[0] <= fault(store[mem_addr]);
            for (int i = 1; i < LAT; i++) rpipe[i] <= rpipe[i-1];
        end
    end
    assign mem_rword = rpipe[LAT-1];

    logic [WW-1:0] ref_w [0:(1<<AW)-1];
    logic cur_en = 0;
    logic [3:0] cur_sel = 0;
    logic held_exp = 0;
    logic [AW-1:0] held_addr_exp = '0;

    bit            exp_mv [0:31], exp_mwe [0:31], exp_rv [0:31], exp_re [0:31], exp_clr [0:31];
    logic [AW-1:0] exp_ma [0:31], exp_rg [0:31];
    logic [WW-1:0] exp_mw [0:31];
    logic [DW-1:0] exp_rd [0:31];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Cycle monitor: compares outputs against scheduled expectations.
    always @(negedge clk) begin
        if (mon_on) begin
            int s;
            s = cyc % 32;
            chk(mem_en == exp_mv[s], "R2 mem_en", mem_en, exp_mv[s]);
            if (exp_mv[s]) begin
                chk(mem_we == exp_mwe[s], "R2 mem_we", mem_we, exp_mwe[s]);
                chk(mem_addr == exp_ma[s], "R2 mem_addr", mem_addr, exp_ma[s]);
                if (exp_mwe[s]) begin
                    chk(mem_wword[15:0] == exp_mw[s][15:0], "R2 data field", mem_wword[15:0], exp_mw[s][15:0]);
                    chk(mem_wword[17] == exp_mw[s][17], "R3 spare column", mem_wword[17], exp_mw[s][17]);
                    chk(mem_wword[16] == exp_mw[s][16], "R4 parity bit", mem_wword[16], exp_mw[s][16]);
                end
            end
            chk(rd_valid == exp_rv[s], "R5 rd_valid", rd_valid, exp_rv[s]);
            if (exp_rv[s]) begin
                chk(rd_data == exp_rd[s], "R5/R6 rd_data", rd_data, exp_rd[s]);
                chk(par_err == exp_re[s], "R7 par_err", par_err, exp_re[s]);
            end else begin
                chk(par_err == 1'b0, "R7 par_err idle", par_err, 0);
            end
            if (exp_rv[s] && exp_re[s] && (!held_exp || exp_clr[s])) begin
                held_exp = 1'b1;
                held_addr_exp = exp_rg[s];
            end else if (exp_clr[s]) begin
                held_exp = 1'b0;
            end
            chk(err_held == held_exp, "R8 err_held", err_held, held_exp);
            if (held_exp) chk(err_addr == held_addr_exp, "R8 err_addr", err_addr, held_addr_exp);
            exp_mv[s] = 0; exp_mwe[s] = 0; exp_rv[s] = 0; exp_re[s] = 0; exp_clr[s] = 0;
        end
    end

    task automatic issue_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic test);
        int k;
        k = (cyc + 1) % 32;
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; par_test = test;
        ref_w[a] = enc(d, cur_en, cur_sel, test);
        exp_mv[k] = 1; exp_mwe[k] = 1; exp_ma[k] = a; exp_mw[k] = ref_w[a];
        tick();
        req_valid = 0; req_write = 0; par_test = 0;
    endtask

    task automatic issue_read(input logic [AW-1:0] a);
        int k, r;
        logic [DW:0] x;
        k = (cyc + 1) % 32;
        r = (cyc + LAT + 2) % 32;
        req_valid = 1; req_write = 0; req_addr = a;
        x = dec(fault(ref_w[a]), cur_en, cur_sel);
        exp_mv[k] = 1; exp_mwe[k] = 0; exp_ma[k] = a;
        exp_rv[r] = 1; exp_rd[r] = x[DW-1:0]; exp_re[r] = x[DW]; exp_rg[r] = a;
        tick();
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic clear_err();
        err_clr = 1;
        exp_clr[(cyc + 1) % 32] = 1;
        tick();
        err_clr = 0;
    endtask

    // R9: configuration write on an idle port applies at the next edge
    task automatic set_cfg(input logic en, input logic [3:0] sel);
        cfg_we = 1; cfg_wdata = {en, sel};
        tick();
        cfg_we = 0;
        cur_en = en; cur_sel = sel;
        chk(cfg_q == {en, sel}, "R9 idle apply", cfg_q, {en, sel});
    endtask

    initial begin
        int unsigned seed;
        int k2;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 32; i++) begin
            ref_w[i] = 18'h10000;
            exp_mv[i] = 0; exp_mwe[i] = 0; exp_rv[i] = 0; exp_re[i] = 0; exp_clr[i] = 0;
        end
        idle(3);
        chk(cfg_q == 0 && mem_en == 0 && mem_we == 0, "R1 reset cfg/mem", {cfg_q, mem_en, mem_we}, 0);
        chk(rd_valid == 0 && par_err == 0 && err_held == 0, "R1 reset read side",
            {rd_valid, par_err, err_held}, 0);
        rst_n = 1; mon_on = 1;
        idle(2);
        chk(cfg_q == 0, "R1 spare disabled after reset", cfg_q, 0);

        // Plain write and read back, spare disabled (R2 R3 R4 R5)
        issue_write(5'd3, 16'hA5C3, 0);
        issue_write(5'd9, 16'h0001, 0);
        issue_read(5'd3);
        issue_read(5'd9);
        idle(LAT + 3);

        // Even parity test write, read flags error and holds address (R4 R7 R8)
        issue_write(5'd4, 16'h1234, 1);
        issue_read(5'd4);
        idle(LAT + 3);
        chk(err_held == 1 && err_addr == 5'd4, "R8 first error captured", {err_held, err_addr}, {1'b1, 5'd4});
        issue_write(5'd6, 16'h00F0, 1);
        issue_read(5'd6);
        idle(LAT + 3);
        chk(err_addr == 5'd4, "R8 later error ignored", err_addr, 5'd4);
        // Clear in the same cycle as a new error: new one captured (R8)
        issue_read(5'd6);
        idle(LAT);
        clear_err();
        chk(err_held == 1 && err_addr == 5'd6, "R8 clear with new error", {err_held, err_addr}, {1'b1, 5'd6});
        idle(2);
        clear_err();
        chk(err_held == 0, "R8 clear releases", err_held, 0);

        // Spare on column 5 masks a stuck column (R3 R6 R7)
        set_cfg(1, 4'd5);
        issue_write(5'd7, 16'h00FF, 0);
        idle(2);
        stuck_col = 5; stuck_val = 0;
        issue_read(5'd7);
        idle(LAT + 3);
        chk(par_err == 0 && err_held == 0, "R6 remapped fault raises no error", {par_err, err_held}, 0);
        // Same stuck column without the spare: wrong bit and parity error (R5 R7)
        set_cfg(0, 4'd0);
        issue_read(5'd7);
        idle(LAT + 3);
        chk(err_held == 1 && err_addr == 5'd7, "R7 unmasked fault detected", {err_held, err_addr}, {1'b1, 5'd7});
        stuck_col = -1;
        clear_err();

        // Configuration write during traffic stays pending (R9)
        issue_read(5'd3);
        issue_read(5'd7);
        k2 = cyc;
        cfg_we = 1; cfg_wdata = {1'b1, 4'd11};
        tick();
        cfg_we = 0;
        while (cyc < k2 + LAT + 1) begin
            chk(cfg_q == 5'd0, "R9 held while busy", cfg_q, 0);
            tick();
        end
        chk(cfg_q == 5'd0, "R9 held on last return", cfg_q, 0);
        tick();
        chk(cfg_q == {1'b1, 4'd11}, "R9 applied when idle", cfg_q, {1'b1, 4'd11});
        cur_en = 1; cur_sel = 11;
        idle(2);

        // Two writes while busy: the last one wins (R10)
        issue_read(5'd1);
        cfg_we = 1; cfg_wdata = {1'b1, 4'd2};
        issue_read(5'd2);
        cfg_wdata = {1'b0, 4'd14};
        tick();
        cfg_we = 0;
        chk(cfg_q == {1'b1, 4'd11}, "R10 old value while busy", cfg_q, {1'b1, 4'd11});
        idle(LAT + 3);
        chk(cfg_q == {1'b0, 4'd14}, "R10 last write applied", cfg_q, {1'b0, 4'd14});
        cur_en = 0; cur_sel = 14;

        // Random traffic in blocks with fresh configuration and faults
        for (int b = 0; b < 8; b++) begin
            idle(LAT + 3);
            clear_err();
            set_cfg(1'($urandom % 2), 4'($urandom % 16));
            if ($urandom % 2) begin
                stuck_col = (cur_en && ($urandom % 2)) ? int'(cur_sel) : int'($urandom % 16);
                stuck_val = 1'($urandom % 2);
            end else begin
                stuck_col = -1;
            end
            for (int i = 0; i < 150; i++) begin
                int r;
                r = $urandom % 8;
                if (r < 3) issue_write(AW'($urandom), DW'($urandom), ($urandom % 8) == 0);
                else if (r < 6) issue_read(AW'($urandom));
                else if (r == 6) clear_err();
                else tick();
            end
        end
        idle(LAT + 3);
        stuck_col = -1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule